// File: doc/BRIEF.md
# Per-Bank Erase-Block Lock Manager

This block tracks write and erase protection for the sixteen erase blocks of one flash bank. It stores one lock flag per block and a bank-wide protection mode. From these it answers, within the same cycle, whether a block named by an array address may be written or erased. It also gives a mask of the blocks whose stored flag is clear, which a bank-wide erase of unlocked blocks can use.

The command decoder drives single-cycle event strobes into the block: enforce protection, lift protection, lock a block, block erased, and bank reset. After power-up or a bank reset, the bank is in a lockdown mode. In that mode every block answers as locked, whatever its stored flag holds, until protection is enforced. Enforcing protection makes the answer follow the stored flags. Lifting protection makes every block writable. A lock request is accepted only while protection is lifted. The stored flags survive a bank reset, and only the power-on reset clears them.

Top module: `blk_lock_mgr`

## Requirements
- R1: The block index of any address is its upper four bits, address[17:14], for both the query address and the command address.
- R2: After the power-on reset, and in the cycle after a bank reset strobe, every block answers locked whatever its stored flag holds.
- R3: In the cycle after an enforce strobe, a block answers locked exactly when its stored flag is set.
- R4: In the cycle after a lift strobe, no block answers locked, including blocks whose stored flag is set.
- R5: A lock request sets the addressed block's stored flag only while protection is lifted. At any other time `lock_reject_o` is high in that cycle and no stored flag changes.
- R6: A block-erased strobe clears that block's stored flag at the next edge. When it coincides with a lock request for the same block, the flag ends clear.
- R7: `query_status_o` is 8'hB0 when the queried block answers locked and 8'h80 otherwise. Bit 7 is ready, bit 5 is erase error and bit 4 is write error. `query_allowed_o` is the inverse of `query_locked_o`.
- R8: `unlocked_mask_o` bit i is the inverse of block i's stored flag in every protection mode, including lockdown.
- R9: A bank reset strobe leaves the stored flags unchanged. The power-on reset clears them all.
- R10: When strobes coincide, bank reset wins over enforce, and enforce wins over lift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bank_rst_i | input | 1 | Bank reset strobe; returns the bank to lockdown mode |
| prot_set_i | input | 1 | Enforce-protection strobe |
| prot_reset_i | input | 1 | Lift-protection strobe |
| lock_req_i | input | 1 | Lock request for the block at cmd_addr_i |
| erase_done_i | input | 1 | Block at cmd_addr_i was erased |
| cmd_addr_i | input | 18 | Array address carried by lock and erase events |
| query_addr_i | input | 18 | Array address of the write or erase under test |
| query_locked_o | output | 1 | Addressed block is effectively locked |
| query_allowed_o | output | 1 | Write or erase to the addressed block may proceed |
| query_status_o | output | 8 | Status byte for the queried operation |
| lock_reject_o | output | 1 | Current lock request is a sequence error |
| unlocked_mask_o | output | 16 | Blocks whose stored flag is clear |

## Verification
The main function, the locked answer, is exercised with the same stored-flag pattern (blocks 3 and 9 flagged) under each of the three protection modes. Only lockdown, enforce and lift then differ, and the answer must change with the mode alone. Queries use addresses whose low bits are nonzero, so a wrong index slice shows up as a wrong block. The flag pattern is then altered by an erase while in lockdown. This separates the mask, which must change at once, from the locked answer, which must not. Coinciding strobes (enforce with lift, bank reset with enforce, and lock with erase on the same block) pin down the priority order.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef enum logic [1:0] {
    PM_LOCKDOWN = 2'd0,
    PM_ENFORCE  = 2'd1,
    PM_OPEN     = 2'd2
  } prot_mode_e;

  localparam logic [7:0] ST_READY   = 8'h80;
  localparam logic [7:0] ST_REFUSED = 8'hB0;

  // Block index = address bits above the in-block offset
  function automatic logic [3:0] blk_of(input logic [17:0] addr);
    return 4'(addr >> 14);
  endfunction
endpackage

// File: rtl/lock_flag_store.sv
module lock_flag_store #(
  parameter int NBLK  = 16,
  parameter int IDX_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NBLK-1:0]  flags
);
  for (genvar g = 0; g < NBLK; g++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(g));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags[g] <= 1'b0;
      else if (hit_clr) flags[g] <= 1'b0;   // erase wins over lock
      else if (hit_set) flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/prot_mode_ctrl.sv
module prot_mode_ctrl
  import blk_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bank_rst,
  input  logic       prot_set,
  input  logic       prot_reset,
  output prot_mode_e mode
);
  prot_mode_e mode_d;
  always_comb begin
    mode_d = mode;
    if (bank_rst)        mode_d = PM_LOCKDOWN;
    else if (prot_set)   mode_d = PM_ENFORCE;
    else if (prot_reset) mode_d = PM_OPEN;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= PM_LOCKDOWN;
    else        mode <= mode_d;
  end
endmodule

// File: rtl/lock_resolve.sv
module lock_resolve
  import blk_lock_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int IDX_W = $clog2(NBLK)
) (
  input  prot_mode_e       mode,
  input  logic [NBLK-1:0]  flags,
  input  logic [IDX_W-1:0] idx,
  output logic             locked,
  output logic [NBLK-1:0]  free_mask
);
  always_comb begin
    unique case (mode)
      PM_ENFORCE: locked = flags[idx];
      PM_OPEN:    locked = 1'b0;
      default:    locked = 1'b1;
    endcase
  end
  assign free_mask = ~flags;
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blk_lock_pkg::*;
#(
  parameter int NBLK   = 16,
  parameter int ADDR_W = 18,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_rst_i,
  input  logic              prot_set_i,
  input  logic              prot_reset_i,
  input  logic              lock_req_i,
  input  logic              erase_done_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] query_addr_i,
  output logic              query_locked_o,
  output logic              query_allowed_o,
  output logic [7:0]        query_status_o,
  output logic              lock_reject_o,
  output logic [NBLK-1:0]   unlocked_mask_o
);
  prot_mode_e       mode;
  logic [NBLK-1:0]  flags;
  logic [IDX_W-1:0] cmd_idx, qry_idx;
  logic             lock_accept;

  assign cmd_idx     = IDX_W'(blk_of(18'(cmd_addr_i)));
  assign qry_idx     = IDX_W'(blk_of(18'(query_addr_i)));
  assign lock_accept = lock_req_i && (mode == PM_OPEN);
  assign lock_reject_o = lock_req_i && !lock_accept;

  prot_mode_ctrl u_mode (
    .clk, .rst_n,
    .bank_rst  (bank_rst_i),
    .prot_set  (prot_set_i),
    .prot_reset(prot_reset_i),
    .mode      (mode)
  );

  lock_flag_store #(.NBLK(NBLK)) u_store (
    .clk, .rst_n,
    .set_en (lock_accept),
    .set_idx(cmd_idx),
    .clr_en (erase_done_i),
    .clr_idx(cmd_idx),
    .flags  (flags)
  );

  lock_resolve #(.NBLK(NBLK)) u_res (
    .mode     (mode),
    .flags    (flags),
    .idx      (qry_idx),
    .locked   (query_locked_o),
    .free_mask(unlocked_mask_o)
  );

  assign query_allowed_o = !query_locked_o;
  assign query_status_o  = query_locked_o ? ST_REFUSED : ST_READY;
endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
  parameter int NBLK   = 16,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_rst_i,
  input logic              prot_set_i,
  input logic              prot_reset_i,
  input logic              lock_req_i,
  input logic              erase_done_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic              query_locked_o,
  input logic              query_allowed_o,
  input logic [7:0]        query_status_o,
  input logic              lock_reject_o,
  input logic [NBLK-1:0]   unlocked_mask_o
);
  assert_lockdown_after_bank_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rst_i |=> query_locked_o);

  assert_lift_opens_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_reset_i && !prot_set_i && !bank_rst_i) |=> !query_locked_o);

  assert_reject_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_reject_o && !erase_done_i) |=> $stable(unlocked_mask_o));

  assert_erase_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done_i |=> unlocked_mask_o[$past(cmd_addr_i[ADDR_W-1 -: 4])]);

  assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    query_locked_o |-> (query_status_o == 8'hB0 && !query_allowed_o));

  assert_bank_rst_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rst_i && !lock_req_i && !erase_done_i) |=> $stable(unlocked_mask_o));
endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.NBLK(NBLK), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_blk_lock_mgr.sv
module tb_blk_lock_mgr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bank_rst_i = 0, prot_set_i = 0, prot_reset_i = 0;
  logic        lock_req_i = 0, erase_done_i = 0;
  logic [17:0] cmd_addr_i = '0, query_addr_i = '0;
  logic        query_locked_o, query_allowed_o, lock_reject_o;
  logic [7:0]  query_status_o;
  logic [15:0] unlocked_mask_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  blk_lock_mgr dut (.*);

  function automatic logic [17:0] addr_of(input int blk);
    return 18'(blk) * 18'h4000 + 18'h1A5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic br, input logic ps, input logic pr,
                       input logic lk, input logic er, input int blk);
    @(negedge clk);
    bank_rst_i = br; prot_set_i = ps; prot_reset_i = pr;
    lock_req_i = lk; erase_done_i = er; cmd_addr_i = addr_of(blk);
    @(negedge clk);
    bank_rst_i = 0; prot_set_i = 0; prot_reset_i = 0; lock_req_i = 0; erase_done_i = 0;
  endtask

  task automatic query(input string req, input int blk, input logic exp_lock);
    query_addr_i = addr_of(blk);
    #1;
    chk(req, query_locked_o, exp_lock);
    chk("R7", query_status_o, exp_lock ? 8'hB0 : 8'h80);
    chk("R7", query_allowed_o, !exp_lock);
  endtask

  task automatic t_reset_state;
    query("R2", 5, 1);
    chk("R8", unlocked_mask_o, 16'hFFFF);
  endtask

  task automatic t_lift_and_lock;
    pulse(0, 0, 1, 0, 0, 0);
    pulse(0, 0, 0, 1, 0, 3);
    chk("R5", lock_reject_o, 0);
    pulse(0, 0, 0, 1, 0, 9);
    chk("R8", unlocked_mask_o, 16'hFDF7);
    query("R4", 3, 0);
    query("R4", 9, 0);
  endtask

  task automatic t_enforce;
    pulse(0, 1, 0, 0, 0, 0);
    query("R3", 3, 1);
    query("R1", 4, 0);
    query("R1", 9, 1);
    @(negedge clk);
    lock_req_i = 1; cmd_addr_i = addr_of(6);
    #1 chk("R5", lock_reject_o, 1);
    @(negedge clk);
    lock_req_i = 0;
    chk("R5", unlocked_mask_o, 16'hFDF7);
  endtask

  task automatic t_bank_reset;
    pulse(1, 0, 0, 0, 0, 0);
    query("R2", 4, 1);
    chk("R9", unlocked_mask_o, 16'hFDF7);
    pulse(0, 0, 0, 0, 1, 3);
    chk("R6", unlocked_mask_o, 16'hFDFF);
    query("R2", 3, 1);
    pulse(0, 1, 0, 0, 0, 0);
    query("R6", 3, 0);
    query("R3", 9, 1);
  endtask

  task automatic t_priority;
    pulse(0, 1, 1, 0, 0, 0);
    query("R10", 9, 1);
    query("R10", 2, 0);
    pulse(1, 1, 0, 0, 0, 0);
    query("R10", 2, 1);
    pulse(0, 0, 1, 0, 0, 0);
    pulse(0, 0, 0, 1, 1, 12);
    chk("R6", unlocked_mask_o, 16'hFDFF);
  endtask

  task automatic t_power_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R9", unlocked_mask_o, 16'hFFFF);
    query("R2", 9, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_lift_and_lock();
        t_enforce();
        t_bank_reset();
        t_priority();
        t_power_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule